// File: doc/BRIEF.md
# Fractional Baud and Frame Timing Generator

This block turns the line-control, integer-divisor and fractional-divisor settings of a serial port into the timing that the transmit and receive shifters need. It keeps an active copy of the configuration. From that copy it produces a one-cycle baud tick at a fixed cycle period, the decoded frame fields (word length, stop-bit count, parity kind) and the length of one whole character in reference-clock cycles, for use by receive-timeout logic.

The settings arrive as plain level inputs. Each cycle the block compares them with the values it saw in the previous cycle (all zeros after reset). A difference that carries a non-zero integer divisor is accepted. An accepted change updates the active fields and the bit period at once and restarts the tick counter. The character length follows one cycle later. A difference that carries a zero integer divisor is not accepted: the active configuration and the running counter stay as they were. Until the first accepted change, the block runs at a default of 8 data bits, one stop bit and no parity, at REF_HZ / DEF_BAUD cycles per bit.

A small controller sequences this with three states. ST_DEFAULT means no configuration has been accepted since reset. ST_APPLY is the single cycle in which the character length is recomputed. ST_RUN means a configuration is active. The transitions are: ST_DEFAULT to ST_APPLY on an accepted change; ST_APPLY to ST_APPLY on a further accepted change, otherwise to ST_RUN; ST_RUN to ST_APPLY on an accepted change, otherwise it stays in ST_RUN. ST_DEFAULT also stays put while nothing is accepted.

Top module: `uart_frame_timing`

## Requirements
- R1: On the rising edge that accepts a change, bit_cycles_o becomes 16 × int_div_i + frac_i + 16.
- R2: On the accepting edge, data_bits_o becomes line_ctl_i[1:0] + 5, which gives 5 to 8 bits.
- R3: On the accepting edge, two_stop_o becomes line_ctl_i[2]. A value of 1 means two stop bits and a value of 0 means one stop bit.
- R4: On the accepting edge, parity_o is decoded from line_ctl_i[5:3]. The codes are: 0xx gives 0 (none), 100 gives 1 (odd), 101 gives 2 (even), 110 gives 3 (forced 1), 111 gives 4 (forced 0).
- R5: One rising edge after the fields change, char_cycles_o equals (data bits + stop bits + 1) × bit_cycles_o. Between the two edges it keeps its previous value.
- R6: A changed input set whose int_div_i is zero leaves the fields, bit_cycles_o and char_cycles_o unchanged. It also does not restart the tick counter.
- R7: After reset the outputs are: data_bits_o = 8, two_stop_o = 0, parity_o = 0, bit_cycles_o = REF_HZ / DEF_BAUD, char_cycles_o = 10 × that value.
- R8: baud_tick_o is high for one cycle out of every bit_cycles_o cycles. After reset release, the first tick appears after the (bit_cycles_o − 1)-th rising edge.
- R9: An accepted change restarts the count. baud_tick_o is low in the cycle where the change is presented, even at terminal count. The next tick appears after the bit_cycles_o-th rising edge, counting the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_ctl_i | input | 6 | Line control: [1:0] word length, [2] stop bits, [5:3] parity |
| int_div_i | input | DIV_W | Integer divisor, zero is rejected |
| frac_i | input | FRAC_W | Fractional cycle add-on |
| baud_tick_o | output | 1 | One-cycle tick per bit period |
| data_bits_o | output | 4 | Active data bits per character |
| two_stop_o | output | 1 | Active stop-bit selection |
| parity_o | output | 3 | Active parity code |
| bit_cycles_o | output | CNT_W | Active cycles per bit |
| char_cycles_o | output | CHAR_W | Cycles per whole character |

## Verification
The terminal count of the tick counter and a presented configuration change can fall in the same cycle. The bench provokes this by waiting until it sees the tick high, then changing the inputs before the next rising edge. For a valid change it expects the tick to drop at once and the next tick exactly one new bit period after the accepting edge. For a change with a zero divisor it expects the tick to stay high and the old period to continue unbroken.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    typedef enum logic [1:0] {
        ST_DEFAULT = 2'd0,
        ST_APPLY   = 2'd1,
        ST_RUN     = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        parity_e    parity;
    } frame_t;

    localparam frame_t FRAME_DEFAULT = '{data_bits: 4'd8, two_stop: 1'b0, parity: PAR_NONE};

    // start bit + data bits + stop bits
    function automatic logic [3:0] frame_bits(input frame_t f);
        return f.data_bits + (f.two_stop ? 4'd2 : 4'd1) + 4'd1;
    endfunction

endpackage

// File: rtl/uft_frame_decode.sv
module uft_frame_decode
    import uft_pkg::*;
(
    input  logic [5:0] line_ctl_i,
    output frame_t     frame_o
);
    always_comb begin
        frame_o.data_bits = {2'b00, line_ctl_i[1:0]} + 4'd5;
        frame_o.two_stop  = line_ctl_i[2];
        if (!line_ctl_i[5]) begin
            frame_o.parity = PAR_NONE;
        end else begin
            unique case (line_ctl_i[4:3])
                2'b00:   frame_o.parity = PAR_ODD;
                2'b01:   frame_o.parity = PAR_EVEN;
                2'b10:   frame_o.parity = PAR_MARK;
                default: frame_o.parity = PAR_SPACE;
            endcase
        end
    end
endmodule

// File: rtl/uft_divisor_calc.sv
module uft_divisor_calc #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int CNT_W  = DIV_W + 5
) (
    input  logic [DIV_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [CNT_W-1:0]  cycles_o
);
    localparam logic [CNT_W-1:0] BASE_ADD = CNT_W'(16);

    always_comb begin
        cycles_o = CNT_W'({int_div_i, 4'b0000}) + CNT_W'(frac_i) + BASE_ADD;
    end
endmodule

// File: rtl/uft_ctrl_fsm.sv
module uft_ctrl_fsm
    import uft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic load_o,
    output logic calc_o
);
    ctrl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DEFAULT: if (accept_i) state_d = ST_APPLY;
            ST_APPLY:   state_d = accept_i ? ST_APPLY : ST_RUN;
            ST_RUN:     if (accept_i) state_d = ST_APPLY;
            default:    state_d = ST_DEFAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DEFAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = 1'b0;
        calc_o = 1'b0;
        unique case (state_q)
            ST_DEFAULT: load_o = accept_i;
            ST_APPLY: begin
                load_o = accept_i;
                calc_o = 1'b1;
            end
            ST_RUN:     load_o = accept_i;
            default: begin
                load_o = 1'b0;
                calc_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uft_baud_counter.sv
module uft_baud_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == period_i - CNT_W'(1));
    assign tick_o = at_end && !reload_i;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (reload_i) cnt_q <= '0;
        else if (at_end)   cnt_q <= '0;
        else               cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/uart_frame_timing.sv
module uart_frame_timing
    import uft_pkg::*;
#(
    parameter int  DIV_W    = 16,
    parameter int  FRAC_W   = 3,
    parameter int  REF_HZ   = 48_000_000,
    parameter int  DEF_BAUD = 9600,
    localparam int CNT_W    = DIV_W + 5,
    localparam int CHAR_W   = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        line_ctl_i,
    input  logic [DIV_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              baud_tick_o,
    output logic [3:0]        data_bits_o,
    output logic              two_stop_o,
    output logic [2:0]        parity_o,
    output logic [CNT_W-1:0]  bit_cycles_o,
    output logic [CHAR_W-1:0] char_cycles_o
);
    localparam logic [CNT_W-1:0]  DEF_BIT  = CNT_W'(REF_HZ / DEF_BAUD);
    localparam logic [CHAR_W-1:0] DEF_CHAR = CHAR_W'(10) * CHAR_W'(DEF_BIT);

    logic [5:0]        lcr_prev_q;
    logic [DIV_W-1:0]  div_prev_q;
    logic [FRAC_W-1:0] frac_prev_q;
    logic              changed, accept, load, calc;
    frame_t            frame_n, frame_q;
    logic [CNT_W-1:0]  bit_n, bit_q;
    logic [CHAR_W-1:0] char_q;

    assign changed = (line_ctl_i != lcr_prev_q) || (int_div_i != div_prev_q) ||
                     (frac_i != frac_prev_q);
    assign accept  = changed && (int_div_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_prev_q  <= '0;
            div_prev_q  <= '0;
            frac_prev_q <= '0;
        end else begin
            lcr_prev_q  <= line_ctl_i;
            div_prev_q  <= int_div_i;
            frac_prev_q <= frac_i;
        end
    end

    uft_frame_decode u_dec (
        .line_ctl_i (line_ctl_i),
        .frame_o    (frame_n)
    );

    uft_divisor_calc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_div (
        .int_div_i (int_div_i),
        .frac_i    (frac_i),
        .cycles_o  (bit_n)
    );

    uft_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .load_o   (load),
        .calc_o   (calc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= FRAME_DEFAULT;
            bit_q   <= DEF_BIT;
        end else if (load) begin
            frame_q <= frame_n;
            bit_q   <= bit_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    char_q <= DEF_CHAR;
        else if (calc) char_q <= CHAR_W'(frame_bits(frame_q)) * CHAR_W'(bit_q);
    end

    uft_baud_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (load),
        .period_i (bit_q),
        .tick_o   (baud_tick_o)
    );

    assign data_bits_o   = frame_q.data_bits;
    assign two_stop_o    = frame_q.two_stop;
    assign parity_o      = frame_q.parity;
    assign bit_cycles_o  = bit_q;
    assign char_cycles_o = char_q;
endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
    parameter int  DIV_W  = 16,
    parameter int  FRAC_W = 3,
    localparam int CNT_W  = DIV_W + 5,
    localparam int CHAR_W = CNT_W + 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        line_ctl_i,
    input logic [DIV_W-1:0]  int_div_i,
    input logic [FRAC_W-1:0] frac_i,
    input logic              baud_tick_o,
    input logic [3:0]        data_bits_o,
    input logic              two_stop_o,
    input logic [2:0]        parity_o,
    input logic [CNT_W-1:0]  bit_cycles_o,
    input logic [CHAR_W-1:0] char_cycles_o
);
    logic [5:0]        p_lcr;
    logic [DIV_W-1:0]  p_div;
    logic [FRAC_W-1:0] p_frac;
    logic              acc, acc_q;
    logic [CNT_W-1:0]  gap_q, exp_tot;
    logic [CHAR_W-1:0] exp_char;

    assign acc = ({line_ctl_i, int_div_i, frac_i} != {p_lcr, p_div, p_frac}) && (int_div_i != 0);
    assign exp_tot = CNT_W'(int_div_i) * CNT_W'(16) + CNT_W'(frac_i) + CNT_W'(16);
    assign exp_char = CHAR_W'(data_bits_o + 4'd1 + (two_stop_o ? 4'd2 : 4'd1)) * CHAR_W'(bit_cycles_o);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_lcr <= '0; p_div <= '0; p_frac <= '0; acc_q <= 1'b0; gap_q <= '0;
        end else begin
            p_lcr <= line_ctl_i; p_div <= int_div_i; p_frac <= frac_i;
            acc_q <= acc;
            gap_q <= (acc || baud_tick_o) ? '0 : gap_q + CNT_W'(1);
        end
    end

    a_r1_bit_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> bit_cycles_o == $past(exp_tot));
    a_r2_data_bits: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> data_bits_o == {2'b00, $past(line_ctl_i[1:0])} + 4'd5);
    a_r3_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> two_stop_o == $past(line_ctl_i[2]));
    a_r5_char_time: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q |-> char_cycles_o == exp_char);
    a_r6_zero_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(bit_cycles_o) && $stable(data_bits_o) && $stable(two_stop_o) && $stable(parity_o));
    a_r8_tick_width: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |=> !baud_tick_o);
    a_r8_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |-> gap_q == bit_cycles_o - CNT_W'(1));
    a_r9_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !baud_tick_o);
endmodule

bind uart_frame_timing uft_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/sim_uart_frame_timing.sv
module sim_uart_frame_timing;
    localparam int DIV_W = 16, FRAC_W = 3, CNT_W = DIV_W + 5, CHAR_W = CNT_W + 4;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic [5:0]        lcr = '0;
    logic [DIV_W-1:0]  div = '0;
    logic [FRAC_W-1:0] frac = '0;
    logic              tick, two_stop;
    logic [3:0]        dbits;
    logic [2:0]        par;
    logic [CNT_W-1:0]  bitc;
    logic [CHAR_W-1:0] charc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    // bench model of the active configuration
    longint e_bits, e_stop, e_par, e_tot, e_char, old_char;

    always #5 clk = ~clk;

    uart_frame_timing u0 (
        .clk(clk), .rst_n(rst_n), .line_ctl_i(lcr), .int_div_i(div), .frac_i(frac),
        .baud_tick_o(tick), .data_bits_o(dbits), .two_stop_o(two_stop), .parity_o(par),
        .bit_cycles_o(bitc), .char_cycles_o(charc)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint f_par(input logic [5:0] l);
        if (!l[5]) return 0;
        return longint'(l[4:3]) + 1;
    endfunction

    function automatic void model_set(input logic [5:0] l, input longint d, input longint f);
        old_char = e_char;
        e_bits = longint'(l[1:0]) + 5;
        e_stop = l[2] ? 2 : 1;
        e_par  = f_par(l);
        e_tot  = 16 * d + f + 16;
        e_char = (e_bits + e_stop + 1) * e_tot;
    endfunction

    task automatic chk_fields(input string tag);
        chk({tag, " R2 data bits"}, dbits, e_bits);
        chk({tag, " R3 stop"}, two_stop, e_stop - 1);
        chk({tag, " R4 parity"}, par, e_par);
        chk({tag, " R1 bit cycles"}, bitc, e_tot);
    endtask

    // called right after inputs were driven at a falling edge
    task automatic follow(input string tag, input longint exp_n, input longint char_mid);
        longint n = 0;
        while (n < 4000) begin
            @(posedge clk); n++;
            @(negedge clk); #1;
            if (n == 1) begin
                chk_fields(tag);
                chk({tag, " R5 char held"}, charc, char_mid);
            end
            if (n == 2) chk({tag, " R5 char time"}, charc, e_char);
            if (tick) break;
        end
        chk({tag, " R8/R9 tick distance"}, n, exp_n);
    endtask

    task automatic apply_valid(input logic [5:0] l, input logic [DIV_W-1:0] d, input logic [FRAC_W-1:0] f,
                               input string tag);
        lcr = l; div = d; frac = f;
        model_set(l, d, f);
        follow(tag, e_tot, old_char);
    endtask

    initial begin
        longint n;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240);
        e_bits = 8; e_stop = 1; e_par = 0; e_tot = 48_000_000 / 9600; e_char = 10 * e_tot;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk_fields("reset R7");
        chk("reset R7 char", charc, 50000);
        chk("reset R7 tick", tick, 0);
        // R8: first tick after reset, then a full period
        n = 0;
        while (n < 6000) begin
            @(posedge clk); n++; @(negedge clk); #1;
            if (tick) break;
        end
        chk("R8 first tick after reset", n, e_tot - 1);
        @(negedge clk); #1;
        chk("R8 tick width", tick, 0);
        @(negedge clk);
        // directed corners: all parity codes and word lengths
        apply_valid(6'b000_0_00, 16'd1, 3'd0, "min div");
        apply_valid(6'b100_1_11, 16'd2, 3'd7, "odd");
        apply_valid(6'b101_0_01, 16'd3, 3'd1, "even");
        apply_valid(6'b110_1_10, 16'd1, 3'd5, "mark");
        apply_valid(6'b111_0_11, 16'd4, 3'd2, "space");
        // random
        for (int i = 0; i < 24; i++) begin
            logic [5:0] l; logic [DIV_W-1:0] d; logic [FRAC_W-1:0] f;
            l = 6'($urandom_range(0, 63));
            d = DIV_W'($urandom_range(1, 6));
            f = FRAC_W'($urandom_range(0, 7));
            if (l == lcr && d == div && f == frac) l = l ^ 6'b000001;
            apply_valid(l, d, f, "random");
        end
        // R6 + collision: zero divisor presented while tick is high
        lcr = lcr ^ 6'b100100; div = '0; frac = frac ^ 3'd1; #1;
        chk("R6 tick kept on zero-div change", tick, 1);
        follow("R6 zero div", e_tot, e_char);
        // R6: zero divisor mid-period does not restart the count
        apply_valid(6'b000_0_11, 16'd5, 3'd3, "pre R6");
        repeat (10) @(negedge clk);
        lcr = 6'b111_1_00; div = '0; #1;
        n = 10;
        while (n < 4000) begin
            @(posedge clk); n++; @(negedge clk); #1;
            if (n == 12) begin chk_fields("R6 mid"); chk("R6 char kept", charc, e_char); end
            if (tick) break;
        end
        chk("R6 counter untouched", n, e_tot);
        // R9 collision: valid change presented while tick is high
        lcr = 6'b101_1_01; div = 16'd2; frac = 3'd6; #1;
        chk("R9 tick suppressed on reload", tick, 0);
        model_set(6'b101_1_01, 2, 6);
        follow("R9 collision", e_tot, old_char);
        // hold inputs: ticks stay periodic with no further reload
        follow("R8 steady period", e_tot, e_char);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule